// File: doc/BRIEF.md
# Serial-Access Flash Program/Erase Sequencer

This block is the front end of a small on-chip user flash. A 16-bit data register can be filled or emptied one bit at a time through a serial input and a serial output. It can also be loaded in one step with the word stored at the current address. A single select line decides which of the two a register step performs.

An address register picks the word. Its top bit picks one of two sectors, and the lower bits pick the word within that sector. The storage behind the register is a plain register array that models the flash contents.

Two request strobes start a self-timed operation:
- A program request ANDs the data register into the addressed word, because programming can only clear bits.
- An erase request sets every word of the addressed sector back to all ones.

Operations start only on the rising edge of a request strobe. A busy output covers the whole operation, for a number of clocks set by a parameter for each kind of operation. Requests that arrive while busy is high are dropped. The address register is frozen until busy falls.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset, busy is 0, ser_out is 0 (the data register clears), the address register holds 0, and every stored word reads 16'hFFFF.
- R2: A clock with reg_step=1 and shift_sel=1 shifts the data register one place toward the MSB. ser_in enters bit 0. ser_out always shows bit 15, so a word leaves MSB first. With reg_step=0 the register holds.
- R3: A clock with reg_step=1 and shift_sel=0 loads the data register in parallel with the word at the address register.
- R4: A clock with addr_ld=1 loads addr_in into the address register only while busy is 0. While busy is 1 the address register keeps its value.
- R5: A rising edge of prog_req while idle raises busy on the next clock and holds it for exactly PROG_CYCLES clocks. When busy falls, the word at the address is the old word ANDed with the data register contents taken at the request.
- R6: A rising edge of erase_req while idle raises busy for exactly ERASE_CYCLES clocks. Then every word whose top address bit matches that of the address register reads 16'hFFFF, and the other sector is unchanged.
- R7: A request held high after its operation ends starts no further operation.
- R8: Rising edges of either strobe while busy is 1 are ignored. The running operation keeps its length, and no second operation follows.
- R9: If prog_req and erase_req rise on the same clock, only the program operation runs (PROG_CYCLES long), and no word is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_step | input | 1 | Data register step enable, acts on the next clock edge |
| shift_sel | input | 1 | 1: serial shift, 0: parallel load from storage |
| ser_in | input | 1 | Serial data into bit 0 |
| ser_out | output | 1 | Serial data out, data register bit 15 |
| addr_in | input | ADDR_W | Address to load |
| addr_ld | input | 1 | Address register load enable |
| prog_req | input | 1 | Program request, acts on its rising edge |
| erase_req | input | 1 | Sector erase request, acts on its rising edge |
| busy | output | 1 | High while an operation runs |

## Verification
The bench builds the block with PROG_CYCLES=3, ERASE_CYCLES=7 and ADDR_W=4. This gives two sectors of eight words each. The whole array can then be swept by serial readout after every erase, and busy lengths can be counted exactly on every operation. The two cycle counts differ, so a program that is run as an erase (or the reverse) shows up in the busy length alone. Directed runs poke addresses and strobe edges in the first busy clock, and seeded random program and erase operations are compared with a bench model of the array.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } pe_op_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/flash_dreg.sv
module flash_dreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         shift_sel,
   input  logic         ser_in,
   input  logic [W-1:0] par_in,
   output logic         ser_out,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_w
      $error("flash_dreg: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (step) begin
         if (shift_sel) q <= {q[W-2:0], ser_in};
         else           q <= par_in;
      end
   end

   assign ser_out = q[W-1];

   // R2
   shift_in_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && shift_sel) |=> (q[0] == $past(ser_in)));

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(q));

   // R3
   par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !shift_sel) |=> (q == $past(par_in)));

endmodule

// File: rtl/flash_areg.sv
module flash_areg #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic          busy,
   input  logic [AW-1:0] d,
   output logic [AW-1:0] q
);

   if (AW < 2) begin : g_bad_aw
      $error("flash_areg: AW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (ld && !busy) q <= d;
   end

   // R4
   addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(q));

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
   import flash_pe_pkg::*;
#(
   parameter int W            = 16,
   parameter int AW           = 4,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_req,
   input  logic          erase_req,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  data,
   output logic          busy,
   output logic          commit,
   output pe_op_e        commit_op,
   output logic [AW-1:0] commit_addr,
   output logic [W-1:0]  commit_data
);

   localparam int MAXC  = max_of(PROG_CYCLES, ERASE_CYCLES);
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_cyc
      $error("flash_pe_ctrl: cycle counts must be at least 1");
   end

   logic             prog_q, erase_q;
   logic             prog_rise, erase_rise, start;
   logic [CNT_W-1:0] cnt;
   pe_op_e           op_q;
   logic [AW-1:0]    addr_s;
   logic [W-1:0]     data_s;

   assign prog_rise  = prog_req  & ~prog_q;
   assign erase_rise = erase_req & ~erase_q;
   assign start      = ~busy & (prog_rise | erase_rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q  <= 1'b0;
         erase_q <= 1'b0;
      end else begin
         prog_q  <= prog_req;
         erase_q <= erase_req;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         op_q   <= OP_PROG;
         addr_s <= '0;
         data_s <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         addr_s <= addr;
         data_s <= data;
         if (prog_rise) begin
            op_q <= OP_PROG;
            cnt  <= CNT_W'(PROG_CYCLES - 1);
         end else begin
            op_q <= OP_ERASE;
            cnt  <= CNT_W'(ERASE_CYCLES - 1);
         end
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign commit      = busy && (cnt == '0);
   assign commit_op   = op_q;
   assign commit_addr = addr_s;
   assign commit_data = data_s;

   // R5
   busy_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(prog_rise || erase_rise));

   // R8
   op_kept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> (busy && $stable(op_q) && $stable(addr_s) && $stable(data_s)));

   // R5
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R7
   done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy);

endmodule

// File: rtl/flash_store.sv
module flash_store
   import flash_pe_pkg::*;
#(
   parameter int W  = 16,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  pe_op_e        op,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DEPTH-1:0][W-1:0] words;

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [AW-1:0] WA = AW'(w);
      logic [W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (commit) begin
            if (op == OP_ERASE && waddr[AW-1] == WA[AW-1]) word_q <= '1;
            else if (op == OP_PROG && waddr == WA)        word_q <= word_q & wdata;
         end
      end
      assign words[w] = word_q;
   end

   assign rdata = words[raddr];

   // R6
   erase_sets_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && op == OP_ERASE && raddr[AW-1] == waddr[AW-1]) |=> (rdata == '1));

   // R5
   prog_ands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && op == OP_PROG && raddr == waddr) |=> (rdata == $past(rdata & wdata)));

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
   import flash_pe_pkg::*;
#(
   parameter int W            = 16,
   parameter int ADDR_W       = 4,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_step,
   input  logic              shift_sel,
   input  logic              ser_in,
   output logic              ser_out,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              addr_ld,
   input  logic              prog_req,
   input  logic              erase_req,
   output logic              busy
);

   if (ADDR_W > 10) begin : g_bad_depth
      $error("flash_pe_seq: ADDR_W too large for a register array");
   end

   logic [W-1:0]      dreg_q, rd_word, c_data;
   logic [ADDR_W-1:0] addr_q, c_addr;
   logic              c_en;
   pe_op_e            c_op;

   flash_areg #(.AW(ADDR_W)) u_areg (
      .clk(clk), .rst_n(rst_n), .ld(addr_ld), .busy(busy),
      .d(addr_in), .q(addr_q)
   );

   flash_dreg #(.W(W)) u_dreg (
      .clk(clk), .rst_n(rst_n), .step(reg_step), .shift_sel(shift_sel),
      .ser_in(ser_in), .par_in(rd_word), .ser_out(ser_out), .q(dreg_q)
   );

   flash_pe_ctrl #(
      .W(W), .AW(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
      .addr(addr_q), .data(dreg_q), .busy(busy), .commit(c_en),
      .commit_op(c_op), .commit_addr(c_addr), .commit_data(c_data)
   );

   flash_store #(.W(W), .AW(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .commit(c_en), .op(c_op), .waddr(c_addr),
      .wdata(c_data), .raddr(addr_q), .rdata(rd_word)
   );

endmodule

// File: tb/flash_pe_seq_tb.sv
module flash_pe_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W     = 16;
   localparam int AW    = 4;
   localparam int PC    = 3;
   localparam int EC    = 7;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_step = 1'b0, shift_sel = 1'b0, ser_in = 1'b0;
   logic addr_ld = 1'b0, prog_req = 1'b0, erase_req = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic ser_out, busy;

   int vectors = 0, fails = 0;
   bit done = 1'b0;
   logic [W-1:0]  model [DEPTH];
   logic [AW-1:0] addr_m;

   flash_pe_seq #(.W(W), .ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_step(reg_step), .shift_sel(shift_sel),
      .ser_in(ser_in), .ser_out(ser_out), .addr_in(addr_in), .addr_ld(addr_ld),
      .prog_req(prog_req), .erase_req(erase_req), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_addr(input logic [AW-1:0] a);
      addr_in = a; addr_ld = 1'b1;
      tick();
      addr_ld = 1'b0;
      addr_m  = a;
   endtask

   task automatic read_word(output logic [W-1:0] v);
      shift_sel = 1'b0; reg_step = 1'b1;
      tick();
      v[W-1] = ser_out;
      for (int i = W-2; i >= 0; i--) begin
         shift_sel = 1'b1; ser_in = 1'b0;
         tick();
         v[i] = ser_out;
      end
      reg_step = 1'b0;
   endtask

   task automatic load_dr(input logic [W-1:0] word);
      for (int i = W-1; i >= 0; i--) begin
         shift_sel = 1'b1; ser_in = word[i]; reg_step = 1'b1;
         tick();
      end
      reg_step = 1'b0;
   endtask

   task automatic check_word(input logic [AW-1:0] a, input string req);
      logic [W-1:0] v;
      set_addr(a);
      read_word(v);
      chk(req, {16'h0, v}, {16'h0, model[a]});
   endtask

   // Starts an operation, optionally holds the strobe or pokes during busy.
   task automatic run_op(input bit is_erase, input bit both, input bit hold,
                         input bit poke_edge, input bit poke_addr,
                         input logic [AW-1:0] poke_a, output int n);
      if (is_erase || both) erase_req = 1'b1;
      if (!is_erase || both) prog_req = 1'b1;
      tick();
      if (!hold) begin prog_req = 1'b0; erase_req = 1'b0; end
      n = 0;
      while (busy && n < 500) begin
         n++;
         if (n == 1) begin
            if (poke_edge) begin
               if (is_erase) prog_req = 1'b1; else erase_req = 1'b1;
            end
            if (poke_addr) begin addr_in = poke_a; addr_ld = 1'b1; end
         end
         tick();
         if (n == 1) begin
            addr_ld = 1'b0;
            if (poke_edge) begin
               if (is_erase) prog_req = 1'b0; else erase_req = 1'b0;
            end
         end
      end
   endtask

   task automatic apply_model(input bit is_erase, input logic [AW-1:0] a, input logic [W-1:0] d);
      if (is_erase) begin
         for (int k = 0; k < DEPTH; k++)
            if (k[AW-1] == a[AW-1]) model[k] = '1;
      end else begin
         model[a] = model[a] & d;
      end
   endtask

   initial begin
      int n;
      int unsigned seed;
      logic [W-1:0] v, d;
      logic [AW-1:0] a;
      bit er;
      for (int k = 0; k < DEPTH; k++) model[k] = '1;
      addr_m = '0;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", {31'h0, busy}, 32'h0);
      chk("R1 ser_out", {31'h0, ser_out}, 32'h0);
      read_word(v);
      chk("R1 addr0 erased", {16'h0, v}, 32'hFFFF);

      // R2 shift in, MSB out first
      load_dr(16'hB26D);
      chk("R2 msb visible", {31'h0, ser_out}, 32'h1);
      reg_step = 1'b0; tick(); tick();
      chk("R2 hold without step", {31'h0, ser_out}, 32'h1);

      // R5 program AND semantics, busy length
      set_addr(4'd3);
      load_dr(16'hA5C3);
      run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, n);
      chk("R5 prog busy len", n, PC);
      apply_model(1'b0, 4'd3, 16'hA5C3);
      check_word(4'd3, "R3 R5 prog word");
      load_dr(16'h0F0F);
      run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, n);
      chk("R5 second prog len", n, PC);
      apply_model(1'b0, 4'd3, 16'h0F0F);
      check_word(4'd3, "R5 AND of two programs");

      // R4 address frozen while busy
      set_addr(4'd5);
      load_dr(16'h1234);
      run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9, n);
      apply_model(1'b0, 4'd5, 16'h1234);
      read_word(v);
      chk("R4 addr held, reads word 5", {16'h0, v}, {16'h0, model[5]});
      check_word(4'd9, "R4 word 9 untouched");

      // R8 edge during busy ignored
      set_addr(4'd2);
      load_dr(16'h0000);
      run_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, n);
      chk("R8 busy len unchanged", n, PC);
      apply_model(1'b0, 4'd2, 16'h0000);
      n = 0;
      for (int k = 0; k < EC + 3; k++) begin
         if (busy) n++;
         tick();
      end
      chk("R8 no second op", n, 0);
      check_word(4'd2, "R8 word not erased");

      // R7 level held
      set_addr(4'd12);
      load_dr(16'h7777);
      run_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, n);
      chk("R7 held prog len", n, PC);
      n = 0;
      for (int k = 0; k < EC + 3; k++) begin
         if (busy) n++;
         tick();
      end
      prog_req = 1'b0;
      chk("R7 no restart while held", n, 0);
      apply_model(1'b0, 4'd12, 16'h7777);
      check_word(4'd12, "R7 word 12");

      // R9 both strobes together
      set_addr(4'd6);
      load_dr(16'h00FF);
      run_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, n);
      chk("R9 program length", n, PC);
      apply_model(1'b0, 4'd6, 16'h00FF);
      for (int k = 0; k < 8; k++) check_word(AW'(k), "R9 sector0 not erased");

      // R6 sector erase
      set_addr(4'd3);
      run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, n);
      chk("R6 erase busy len", n, EC);
      apply_model(1'b1, 4'd3, '0);
      for (int k = 0; k < DEPTH; k++) check_word(AW'(k), "R6 sweep after erase");

      // Random mix
      for (int it = 0; it < 40; it++) begin
         a  = AW'($urandom);
         d  = W'($urandom);
         er = ($urandom % 4) == 0;
         set_addr(a);
         if (!er) load_dr(d);
         run_op(er, 1'b0, 1'b0, 1'b0, 1'b0, '0, n);
         chk(er ? "R6 rand erase len" : "R5 rand prog len", n, er ? EC : PC);
         apply_model(er, a, d);
         check_word(AW'($urandom), er ? "R6 rand read" : "R5 rand read");
      end
      for (int k = 0; k < DEPTH; k++) check_word(AW'(k), "R5 R6 final sweep");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule